// File: doc/BRIEF.md
# Grouped Pin Interrupt Detector

This block watches a small group of input pins and raises one interrupt request for the whole group. Each pin can be switched in or out of the group and given its own active sense. The selected pins, adjusted for their sense, are ORed into a single "group asserted" signal. A single shared detector then turns that signal into events on the bus clock. A port-wide mode bit picks one of two behaviours. In the first, only a transition of the group signal from inactive to active counts. In the second, the group signal being active also counts, on every cycle that it is active.

An event sets a sticky flag. The flag drives the interrupt request only while the interrupt enable is on. Software clears the flag by writing a one to a self-clearing acknowledge bit. The block has a plain single-cycle register port for writes and a combinational read port. Because all pins share one detector, an edge on one pin is not seen while another enabled pin is already active. Software must take that into account.

Top module: `pin_irq_port`

## Requirements
- R1: After reset every register reads 0, the flag is 0 and `irq` is 0.
- R2: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R3: Sense bit n = 0 makes pin n active low (falling edge). Sense bit n = 1 makes it active high (rising edge). A transition away from the active level sets no flag in edge mode.
- R4: A group edge is a sample at the inactive level followed by a sample at the active level on the next clock. Pins pass through two synchronizer flops, so the flag reads 1 after the third rising clock edge following a pin change, and still reads 0 after the second.
- R5: The flag stays set until acknowledged. `irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1.
- R6: Writing control with bit 2 = 1 clears the flag on that clock edge. Bit 2 always reads back 0.
- R7: In edge mode (control bit 0 = 0), an active edge on one enabled pin sets no flag while another enabled pin is already at its active level.
- R8: In level mode (control bit 0 = 1), the flag is set on every cycle the group signal is active, so an acknowledge does not clear it while an enabled pin stays active.
- R9: When an event and an acknowledge arrive on the same clock edge, the flag ends up 1.
- R10: Any write to the enable or sense register, and any control write that changes the mode bit, cannot by itself produce an edge. Enabling a pin that is already at its active level sets no flag in edge mode.
- R11: Register map, selected by `addr`: 0 = control (bit 0 mode, bit 1 interrupt enable, bit 2 acknowledge (write only), bit 3 flag (read only)); 1 = pin enable mask, pin n at bit n; 2 = pin sense mask, pin n at bit n; 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | NPINS | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows up on `irq` and on control bit 3 no later than the third clock edge after the pin change that should or should not have produced an event. Some faults leave no trace at all until a second pin is involved. A stale previous-sample register after a configuration write, for example, shows as a spurious flag one cycle after the write. A detector that works per pin instead of on the merged signal only shows when one pin is held active while another toggles. The directed scenarios therefore hold one pin active while others change. They also time an acknowledge to land exactly on the event edge, and read the flag on the cycles just before and just after it is due.

// File: rtl/pin_irq_pkg.sv
// Shared constants for the grouped pin interrupt detector.
// Assumes a 2-bit register select; bit positions inside the control
// register are fixed here so software and bench agree on them.
package pin_irq_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_SENSE  = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_ACK_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 3;

endpackage

// File: rtl/pin_irq_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes pins are asynchronous to clk; output lags input by two edges.
module pin_irq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_chain
        logic meta_q;
        logic stable_q;

        // Move pin i into the clock domain through two flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= din[i];
                stable_q <= meta_q;
            end
        end

        assign dout[i] = stable_q;
    end

endmodule

// File: rtl/pin_irq_merge.sv
// Applies per-pin enable and sense, then ORs the pins into one group signal.
// Assumes synchronized inputs; purely combinational.
module pin_irq_merge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] pin_en,
    input  logic [W-1:0] pin_sense,
    output logic         grp_active
);

    logic [W-1:0] active_vec;

    // A pin is active when it matches its sense bit and is enabled.
    always_comb begin
        active_vec = pin_en & ~(pin_sync ^ pin_sense);
        grp_active = |active_vec;
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en == '0) |-> !grp_active); // R2

endmodule

// File: rtl/pin_irq_event.sv
// Shared edge detector, sticky flag and request gating.
// Assumes cfg_touch pulses for one cycle on every configuration write and
// ack_wr pulses for one cycle on an acknowledge write.
module pin_irq_event (
    input  logic clk,
    input  logic rst_n,
    input  logic grp_active,
    input  logic level_mode,
    input  logic irq_en,
    input  logic ack_wr,
    input  logic cfg_touch,
    output logic flag,
    output logic irq
);

    logic prev_q;
    logic flag_q;
    logic edge_hit;
    logic set_evt;

    // Remember the last group sample; a config write marks it active so a
    // fresh inactive sample is needed before the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (cfg_touch) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= grp_active;
        end
    end

    // Form the event from an edge, or from the level in level mode.
    always_comb begin
        edge_hit = grp_active & ~prev_q;
        set_evt  = edge_hit | (level_mode & grp_active);
    end

    // Sticky flag: set beats acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (ack_wr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack_wr) |=> flag_q); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !set_evt) |=> !flag_q); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R9
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && grp_active) |=> flag_q); // R8
    AST_NO_CFG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_touch |=> !edge_hit); // R10

endmodule

// File: rtl/pin_irq_regs.sv
// Register file: mode, interrupt enable, pin enable and sense masks,
// acknowledge strobe and read mux. Assumes DW >= NPINS and DW >= 4.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              flag,
    output logic [DW-1:0]     rdata,
    output logic              level_mode,
    output logic              irq_en,
    output logic [NPINS-1:0]  pin_en,
    output logic [NPINS-1:0]  pin_sense,
    output logic              ack_wr,
    output logic              cfg_touch
);

    logic wr_ctrl;
    logic wr_en_reg;
    logic wr_sense;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    // Decode the write target.
    always_comb begin
        wr_ctrl   = wr_en && (addr == REG_CTRL);
        wr_en_reg = wr_en && (addr == REG_ENABLE);
        wr_sense  = wr_en && (addr == REG_SENSE);
        ack_wr    = wr_ctrl && wdata[CTRL_ACK_BIT];
        cfg_touch = wr_en_reg || wr_sense ||
                    (wr_ctrl && (wdata[CTRL_MODE_BIT] != level_mode));
    end

    // Hold the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_mode <= 1'b0;
            irq_en     <= 1'b0;
        end else if (wr_ctrl) begin
            level_mode <= wdata[CTRL_MODE_BIT];
            irq_en     <= wdata[CTRL_IE_BIT];
        end
    end

    // Hold the per-pin masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en    <= '0;
            pin_sense <= '0;
        end else begin
            if (wr_en_reg) pin_en    <= wdata[NPINS-1:0];
            if (wr_sense)  pin_sense <= wdata[NPINS-1:0];
        end
    end

    // Return the selected register; acknowledge always reads 0.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL: begin
                rdata[CTRL_MODE_BIT] = level_mode;
                rdata[CTRL_IE_BIT]   = irq_en;
                rdata[CTRL_FLAG_BIT] = flag;
            end
            REG_ENABLE: rdata[NPINS-1:0] = pin_en;
            REG_SENSE:  rdata[NPINS-1:0] = pin_sense;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_irq_port.sv
// Grouped pin interrupt detector top level.
// Chain: synchronizer -> enable/sense merge -> shared event detector,
// configured through pin_irq_regs. Assumes one clock, synchronous reset.
module pin_irq_port
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] pin_en;
    logic [NPINS-1:0] pin_sense;
    logic             grp_active;
    logic             level_mode;
    logic             irq_en;
    logic             ack_wr;
    logic             cfg_touch;
    logic             flag;

    pin_irq_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (pin_sync)
    );

    pin_irq_merge #(.W(NPINS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync   (pin_sync),
        .pin_en     (pin_en),
        .pin_sense  (pin_sense),
        .grp_active (grp_active)
    );

    pin_irq_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .flag       (flag),
        .rdata      (rdata),
        .level_mode (level_mode),
        .irq_en     (irq_en),
        .pin_en     (pin_en),
        .pin_sense  (pin_sense),
        .ack_wr     (ack_wr),
        .cfg_touch  (cfg_touch)
    );

    pin_irq_event u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .grp_active (grp_active),
        .level_mode (level_mode),
        .irq_en     (irq_en),
        .ack_wr     (ack_wr),
        .cfg_touch  (cfg_touch),
        .flag       (flag),
        .irq        (irq)
    );

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R5

endmodule

// File: tb/pin_irq_port_bench.sv
`timescale 1ns/1ps
module pin_irq_port_bench;

    localparam int NPINS = 4;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NPINS-1:0] pins = '1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    pin_irq_port #(.NPINS(NPINS), .DW(DW)) u_pin_irq_port (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; #1;
        d = rdata;
        addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic flag_now();
        return rdata[3];
    endfunction

    task automatic clean();
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h04);
        idle(4);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1", "register after reset", v, 0);
        end
        chk("R1", "irq after reset", irq, 0);
    endtask

    task automatic t_regmap();
        logic [DW-1:0] v;
        wr(2'd1, 8'h0A); rd(2'd1, v); chk("R11", "enable readback", v, 8'h0A);
        wr(2'd2, 8'h05); rd(2'd2, v); chk("R11", "sense readback", v, 8'h05);
        wr(2'd0, 8'h07); rd(2'd0, v); chk("R6", "ack reads 0, ctrl", v, 8'h03);
        rd(2'd3, v); chk("R11", "spare reads 0", v, 0);
        clean();
    endtask

    task automatic t_disabled();
        clean();
        wr(2'd1, 8'h02);
        idle(3);
        @(negedge clk); pins[0] = 1'b0;
        idle(5);
        chk("R2", "disabled pin flag", flag_now(), 0);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
        chk("R2", "disabled pin release flag", flag_now(), 0);
    endtask

    task automatic t_falling();
        clean();
        wr(2'd1, 8'h01);
        idle(3);
        @(negedge clk); pins[0] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R4", "flag after 2 edges", flag_now(), 0);
        @(posedge clk); #1;
        chk("R4", "flag after 3 edges", flag_now(), 1);
        chk("R5", "irq with ie off", irq, 0);
        wr(2'd0, 8'h02);
        chk("R5", "irq with ie on", irq, 1);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
        chk("R5", "flag sticky after release", flag_now(), 1);
        wr(2'd0, 8'h06);
        chk("R6", "flag after ack", flag_now(), 0);
        chk("R6", "irq after ack", irq, 0);
    endtask

    task automatic t_rising();
        clean();
        @(negedge clk); pins[1] = 1'b0;
        idle(4);
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h02);
        idle(4);
        chk("R3", "rising pin idle low", flag_now(), 0);
        @(negedge clk); pins[1] = 1'b1;
        idle(3);
        chk("R3", "rising edge sets flag", flag_now(), 1);
        wr(2'd0, 8'h04);
        @(negedge clk); pins[1] = 1'b0;
        idle(4);
        chk("R3", "falling edge on rising pin", flag_now(), 0);
        clean();
        @(negedge clk); pins[1] = 1'b1;
        idle(4);
    endtask

    task automatic t_masked();
        clean();
        @(negedge clk); pins[1] = 1'b0;
        idle(4);
        wr(2'd1, 8'h03);
        idle(4);
        chk("R10", "enable of active pin", flag_now(), 0);
        @(negedge clk); pins[0] = 1'b0;
        idle(5);
        chk("R7", "edge masked by active pin", flag_now(), 0);
        @(negedge clk); pins[1] = 1'b1;
        idle(4);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
        chk("R7", "no flag after releases", flag_now(), 0);
        @(negedge clk); pins[0] = 1'b0;
        idle(3);
        chk("R7", "edge with other pin idle", flag_now(), 1);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
    endtask

    task automatic t_level();
        clean();
        wr(2'd1, 8'h04);
        wr(2'd0, 8'h01);
        idle(3);
        chk("R8", "level mode idle", flag_now(), 0);
        @(negedge clk); pins[2] = 1'b0;
        idle(3);
        chk("R8", "level sets flag", flag_now(), 1);
        wr(2'd0, 8'h05);
        chk("R8", "ack while held", flag_now(), 1);
        idle(2);
        chk("R8", "still set while held", flag_now(), 1);
        @(negedge clk); pins[2] = 1'b1;
        idle(3);
        wr(2'd0, 8'h05);
        chk("R8", "ack after release", flag_now(), 0);
        wr(2'd0, 8'h04);
    endtask

    task automatic t_collide();
        clean();
        wr(2'd1, 8'h01);
        idle(3);
        @(negedge clk); pins[0] = 1'b0;
        @(posedge clk); @(posedge clk);
        wr(2'd0, 8'h04);
        chk("R9", "set beats ack", flag_now(), 1);
        @(negedge clk); pins[0] = 1'b1;
        idle(4);
        wr(2'd0, 8'h04);
        chk("R6", "later ack clears", flag_now(), 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_disabled();
        t_falling();
        t_rising();
        t_masked();
        t_level();
        t_collide();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule